// File: doc/BRIEF.md
# Control-Write Sequencer for the Default Control Endpoint

This block sequences control write transfers on a USB device's default control endpoint. On one side is a packet interface from the serial interface engine. That interface reports the start and end of each transaction, the token kind, and the payload bytes of a setup packet. On the other side is a small register interface for the local CPU. The block stores the eight setup bytes in a bank the CPU can read. It raises three interrupt flags: setup received, data-stage OUT token seen and status-stage IN token seen. It returns a handshake code for each transaction in the cycle the end-of-transaction strobe arrives.

After a good setup the block sets a status hold bit by itself. While that bit is set, every status-stage IN token gets a NAK, which gives the CPU time to decide the outcome. Once the CPU clears the bit, the status stage is answered with a zero-length packet or, if the CPU has set the endpoint stall bit, with STALL. A new setup that arrives while the previous setup flag is still set gets no response at all, so the stored bytes stay intact until the CPU has dealt with them.

The handshake code on `hs_code` is 0 for no response, 1 for ACK (for an IN token this means send a zero-length packet), 2 for NAK and 3 for STALL. The token kind on `tok_kind` is 1 for SETUP, 2 for OUT and 3 for IN; 0 starts nothing.

CPU register map, by `cpu_addr`:
- 0 to 7: setup bytes in arrival order (read only).
- 8: flags. Bit 0 is setup, bit 1 is data OUT and bit 2 is status IN. Writing 1 to a bit clears that flag.
- 9: interrupt enables, with the same bit layout as the flags.
- 10: control. Bit 0 is the status hold bit and bit 1 is the endpoint stall bit.

Top module: `ctrl_ep_seq`

## Requirements
- R1: After reset all flags, enables, the hold bit and the stall bit are 0, `irq_n` is 1 and `hs_code` is 0.
- R2: The bytes of an accepted SETUP are stored in arrival order and read at addresses 0 to 7. Any bytes after the eighth are ignored.
- R3: An accepted SETUP with at least eight bytes gets code 1 at `tok_done`. From the next cycle the setup flag (bit 0 at address 8) and the hold bit (bit 0 at address 10) are both 1.
- R4: A SETUP that starts while the setup flag is 1 gets code 0 and leaves all eight stored bytes unchanged.
- R5: An accepted SETUP that carries fewer than eight bytes gets code 0 and does not set the setup flag or the hold bit.
- R6: Each OUT start sets the data flag (bit 1) from the next cycle. At `tok_done` the OUT gets code 3 when the stall bit is 1 and code 1 otherwise.
- R7: Each IN start sets the status flag (bit 2) from the next cycle. While the hold bit is 1, the IN gets code 2 at `tok_done`.
- R8: With the hold bit at 0, an IN gets code 3 when the stall bit is 1 and code 1 (zero-length packet) otherwise.
- R9: Writing 1 to a flag bit at address 8 clears that flag. When a clear and a set of the same flag fall in the same cycle, the set wins.
- R10: `irq_n` is 0 exactly when some flag and its enable bit (address 9, same layout) are both 1.
- R11: `hs_code` is 0 in every cycle where `tok_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tok_start | input | 1 | Start-of-transaction strobe |
| tok_kind | input | 2 | Token kind, sampled with `tok_start` |
| rx_valid | input | 1 | Setup payload byte valid |
| rx_data | input | 8 | Setup payload byte |
| tok_done | input | 1 | End-of-transaction strobe |
| hs_code | output | 2 | Handshake decision, valid while `tok_done` is 1 |
| cpu_we | input | 1 | CPU register write strobe |
| cpu_addr | input | 4 | CPU register address |
| cpu_wdata | input | 3 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, combinational from `cpu_addr` |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The assertions assume the packet interface behaves well: `tok_done` never falls in the same cycle as `tok_start` or `rx_valid`, each transaction begins with `tok_start` and ends with one `tok_done`, and the CPU does not write the flags while a SETUP is still in flight. The stimulus keeps to these rules because each transaction is driven by a task that fully completes the start, payload and done phases in turn. CPU accesses run only between transactions. The one exception is a directed case that puts a flag clear in the same cycle as an IN start, which is legal under these rules. Random payload lengths, register values and orderings then cover the refusal, short-packet, stall and hold cases.

// File: rtl/cseq_pkg.sv
package cseq_pkg;
    typedef enum logic [1:0] {
        HS_NONE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_NAK   = 2'd2,
        HS_STALL = 2'd3
    } hs_e;

    typedef enum logic [1:0] {
        TK_IDLE  = 2'd0,
        TK_SETUP = 2'd1,
        TK_OUT   = 2'd2,
        TK_IN    = 2'd3
    } tok_e;

    localparam int NFLAG      = 3;
    localparam int FLG_SETUP  = 0;
    localparam int FLG_DOUT   = 1;
    localparam int FLG_STATUS = 2;
endpackage

// File: rtl/cseq_setup_capture.sv
module cseq_setup_capture #(
    parameter int NBYTES = 8,
    parameter int DW     = 8,
    localparam int CW    = $clog2(NBYTES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 open_i,
    input  logic                 rx_en_i,
    input  logic [DW-1:0]        rx_data_i,
    output logic [CW-1:0]        count_o,
    output logic [NBYTES*DW-1:0] bank_o
);
    typedef struct packed {
        logic [CW-1:0]        count;
        logic [NBYTES*DW-1:0] bank;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (open_i) begin
            cap_d.count = '0;
        end else if (rx_en_i && (cap_q.count < CW'(NBYTES))) begin
            cap_d.bank[int'(cap_q.count)*DW +: DW] = rx_data_i;
            cap_d.count = cap_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign count_o = cap_q.count;
    assign bank_o  = cap_q.bank;
endmodule

// File: rtl/cseq_handshake.sv
module cseq_handshake
    import cseq_pkg::*;
(
    input  logic       done_i,
    input  logic       active_i,
    input  tok_e       kind_i,
    input  logic       setup_ok_i,
    input  logic       hold_i,
    input  logic       stall_i,
    output hs_e        hs_o
);
    always_comb begin
        hs_o = HS_NONE;
        if (done_i && active_i) begin
            unique case (kind_i)
                TK_SETUP: hs_o = setup_ok_i ? HS_ACK : HS_NONE;
                TK_OUT:   hs_o = stall_i ? HS_STALL : HS_ACK;
                TK_IN:    hs_o = hold_i ? HS_NAK : (stall_i ? HS_STALL : HS_ACK);
                default:  hs_o = HS_NONE;
            endcase
        end
    end
endmodule

// File: rtl/cseq_regs.sv
module cseq_regs
    import cseq_pkg::*;
#(
    parameter int AW        = 4,
    parameter int ADDR_FLG  = 8,
    parameter int ADDR_EN   = 9,
    parameter int ADDR_CTL  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [NFLAG-1:0] wdata_i,
    input  logic [NFLAG-1:0] set_i,
    input  logic             hold_set_i,
    output logic [NFLAG-1:0] flags_o,
    output logic [NFLAG-1:0] en_o,
    output logic             hold_o,
    output logic             stall_o,
    output logic             irq_n_o
);
    typedef struct packed {
        logic [NFLAG-1:0] flags;
        logic [NFLAG-1:0] en;
        logic             hold;
        logic             stall;
    } reg_t;

    reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we_i && addr_i == AW'(ADDR_FLG)) r_d.flags = r_q.flags & ~wdata_i;
        if (we_i && addr_i == AW'(ADDR_EN))  r_d.en = wdata_i;
        if (we_i && addr_i == AW'(ADDR_CTL)) begin
            r_d.hold  = wdata_i[0];
            r_d.stall = wdata_i[1];
        end
        r_d.flags = r_d.flags | set_i;
        if (hold_set_i) r_d.hold = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign flags_o = r_q.flags;
    assign en_o    = r_q.en;
    assign hold_o  = r_q.hold;
    assign stall_o = r_q.stall;
    assign irq_n_o = ~|(r_q.flags & r_q.en);
endmodule

// File: rtl/ctrl_ep_seq.sv
module ctrl_ep_seq
    import cseq_pkg::*;
#(
    parameter int NBYTES = 8,
    parameter int DW     = 8,
    parameter int AW     = 4,
    localparam int CW       = $clog2(NBYTES + 1),
    localparam int ADDR_FLG = NBYTES,
    localparam int ADDR_EN  = NBYTES + 1,
    localparam int ADDR_CTL = NBYTES + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_start,
    input  logic [1:0]       tok_kind,
    input  logic             rx_valid,
    input  logic [DW-1:0]    rx_data,
    input  logic             tok_done,
    output logic [1:0]       hs_code,
    input  logic             cpu_we,
    input  logic [AW-1:0]    cpu_addr,
    input  logic [NFLAG-1:0] cpu_wdata,
    output logic [DW-1:0]    cpu_rdata,
    output logic             irq_n
);
    typedef struct packed {
        logic active;
        tok_e kind;
        logic accept;
    } trk_t;

    trk_t trk_d, trk_q;

    logic                 act_w, acc_w;
    tok_e                 kind_w;
    logic [CW-1:0]        count_w;
    logic [NBYTES*DW-1:0] bank_w;
    logic [NFLAG-1:0]     flags_w, en_w, set_w;
    logic                 hold_w, stall_w;
    logic                 setup_open, setup_ok, setup_done, rx_en;
    hs_e                  hs_w;

    assign setup_open = tok_start && (tok_e'(tok_kind) == TK_SETUP) && !flags_w[FLG_SETUP];
    assign rx_en      = rx_valid && trk_q.active && trk_q.accept && (trk_q.kind == TK_SETUP);
    assign setup_ok   = trk_q.active && trk_q.accept && (trk_q.kind == TK_SETUP)
                        && (count_w == CW'(NBYTES));
    assign setup_done = tok_done && setup_ok;

    always_comb begin
        trk_d = trk_q;
        if (tok_start && (tok_e'(tok_kind) != TK_IDLE)) begin
            trk_d.active = 1'b1;
            trk_d.kind   = tok_e'(tok_kind);
            trk_d.accept = setup_open;
        end else if (tok_done) begin
            trk_d.active = 1'b0;
            trk_d.accept = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '{active: 1'b0, kind: TK_IDLE, accept: 1'b0};
        else        trk_q <= trk_d;
    end

    assign act_w  = trk_q.active;
    assign kind_w = trk_q.kind;
    assign acc_w  = trk_q.accept;

    always_comb begin
        set_w             = '0;
        set_w[FLG_SETUP]  = setup_done;
        set_w[FLG_DOUT]   = tok_start && (tok_e'(tok_kind) == TK_OUT);
        set_w[FLG_STATUS] = tok_start && (tok_e'(tok_kind) == TK_IN);
    end

    cseq_setup_capture #(.NBYTES(NBYTES), .DW(DW)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .open_i    (setup_open),
        .rx_en_i   (rx_en),
        .rx_data_i (rx_data),
        .count_o   (count_w),
        .bank_o    (bank_w)
    );

    cseq_regs #(.AW(AW), .ADDR_FLG(ADDR_FLG), .ADDR_EN(ADDR_EN), .ADDR_CTL(ADDR_CTL)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (cpu_we),
        .addr_i     (cpu_addr),
        .wdata_i    (cpu_wdata),
        .set_i      (set_w),
        .hold_set_i (setup_done),
        .flags_o    (flags_w),
        .en_o       (en_w),
        .hold_o     (hold_w),
        .stall_o    (stall_w),
        .irq_n_o    (irq_n)
    );

    cseq_handshake u_hs (
        .done_i     (tok_done),
        .active_i   (trk_q.active),
        .kind_i     (trk_q.kind),
        .setup_ok_i (setup_ok),
        .hold_i     (hold_w),
        .stall_i    (stall_w),
        .hs_o       (hs_w)
    );

    assign hs_code = hs_w;

    always_comb begin
        cpu_rdata = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (cpu_addr == AW'(i)) cpu_rdata = bank_w[i*DW +: DW];
        end
        if (cpu_addr == AW'(ADDR_FLG)) cpu_rdata = DW'(flags_w);
        if (cpu_addr == AW'(ADDR_EN))  cpu_rdata = DW'(en_w);
        if (cpu_addr == AW'(ADDR_CTL)) cpu_rdata = DW'({stall_w, hold_w});
    end
endmodule

// File: rtl/cseq_sva.sv
module cseq_sva
    import cseq_pkg::*;
#(
    parameter int NBYTES = 8,
    parameter int DW     = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tok_start,
    input logic [1:0]           tok_kind,
    input logic                 tok_done,
    input logic [1:0]           hs_code,
    input logic                 active,
    input tok_e                 kind,
    input logic                 accept,
    input logic [NBYTES*DW-1:0] bank,
    input logic [NFLAG-1:0]     flags,
    input logic                 hold,
    input logic                 stall
);
    AST_HS_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !tok_done |-> hs_code == 2'd0); // R11

    AST_SETUP_ACK_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_done && active && kind == TK_SETUP && hs_code == 2'd1)
        |=> (flags[FLG_SETUP] && hold)); // R3

    AST_REFUSED_KEEPS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (active && kind == TK_SETUP && !accept) |=> $stable(bank)); // R4

    AST_REFUSED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_done && active && kind == TK_SETUP && !accept) |-> hs_code == 2'd0); // R4

    AST_OUT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_start && tok_kind == 2'd2) |=> flags[FLG_DOUT]); // R6

    AST_OUT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_done && active && kind == TK_OUT && stall) |-> hs_code == 2'd3); // R6

    AST_IN_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_start && tok_kind == 2'd3) |=> flags[FLG_STATUS]); // R7

    AST_HOLD_NAKS: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_done && active && kind == TK_IN && hold) |-> hs_code == 2'd2); // R7

    AST_RELEASED_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_done && active && kind == TK_IN && !hold)
        |-> hs_code == (stall ? 2'd3 : 2'd1)); // R8
endmodule

bind ctrl_ep_seq cseq_sva #(.NBYTES(NBYTES), .DW(DW)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .tok_start (tok_start),
    .tok_kind  (tok_kind),
    .tok_done  (tok_done),
    .hs_code   (hs_code),
    .active    (act_w),
    .kind      (kind_w),
    .accept    (acc_w),
    .bank      (bank_w),
    .flags     (flags_w),
    .hold      (hold_w),
    .stall     (stall_w)
);

// File: tb/tb_ctrl_ep_seq.sv
module tb_ctrl_ep_seq;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tok_start = 1'b0;
    logic [1:0] tok_kind = 2'd0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'd0;
    logic       tok_done = 1'b0;
    logic [1:0] hs_code;
    logic       cpu_we = 1'b0;
    logic [3:0] cpu_addr = 4'd0;
    logic [2:0] cpu_wdata = 3'd0;
    logic [7:0] cpu_rdata;
    logic       irq_n;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] m_bank [8];
    logic [2:0] m_flags = 3'd0;
    logic [2:0] m_en    = 3'd0;
    logic       m_hold  = 1'b0;
    logic       m_stall = 1'b0;

    ctrl_ep_seq dut (
        .clk(clk), .rst_n(rst_n), .tok_start(tok_start), .tok_kind(tok_kind),
        .rx_valid(rx_valid), .rx_data(rx_data), .tok_done(tok_done), .hs_code(hs_code),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .irq_n(irq_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [1:0] exp_in_code();
        return m_hold ? 2'd2 : (m_stall ? 2'd3 : 2'd1);
    endfunction

    function automatic logic [7:0] exp_reg(input int a);
        if (a < 8)   return m_bank[a];
        if (a == 8)  return {5'd0, m_flags};
        if (a == 9)  return {5'd0, m_en};
        if (a == 10) return {6'd0, m_stall, m_hold};
        return 8'd0;
    endfunction

    task automatic check_irq(input string tag);
        check(tag, int'(irq_n), int'(~|(m_flags & m_en)));
    endtask

    task automatic read_chk(input string tag, input int a);
        cpu_addr = 4'(a);
        #1;
        check(tag, int'(cpu_rdata), int'(exp_reg(a)));
    endtask

    task automatic cpu_write(input int a, input logic [2:0] d);
        cpu_we = 1'b1; cpu_addr = 4'(a); cpu_wdata = d;
        tick();
        cpu_we = 1'b0;
        if (a == 8)  m_flags = m_flags & ~d;
        if (a == 9)  m_en = d;
        if (a == 10) begin m_hold = d[0]; m_stall = d[1]; end
    endtask

    task automatic do_setup(input int n, input logic [7:0] seed, input string tag);
        logic       acc;
        logic [1:0] exp;
        acc = !m_flags[0];
        tok_start = 1'b1; tok_kind = 2'd1;
        tick();
        tok_start = 1'b0; tok_kind = 2'd0;
        for (int i = 0; i < n; i++) begin
            rx_valid = 1'b1; rx_data = seed + 8'(i * 37);
            if (acc && i < 8) m_bank[i] = rx_data;
            tick();
        end
        rx_valid = 1'b0;
        tok_done = 1'b1;
        exp = (acc && n >= 8) ? 2'd1 : 2'd0;
        #1;
        check(tag, int'(hs_code), int'(exp));
        tick();
        tok_done = 1'b0;
        if (exp == 2'd1) begin m_flags[0] = 1'b1; m_hold = 1'b1; end
    endtask

    task automatic do_data_out(input string tag);
        tok_start = 1'b1; tok_kind = 2'd2;
        tick();
        tok_start = 1'b0; tok_kind = 2'd0;
        m_flags[1] = 1'b1;
        read_chk({tag, " R6 flag"}, 8);
        tok_done = 1'b1;
        #1;
        check({tag, " R6 code"}, int'(hs_code), m_stall ? 3 : 1);
        tick();
        tok_done = 1'b0;
    endtask

    task automatic do_status_in(input string tag);
        tok_start = 1'b1; tok_kind = 2'd3;
        tick();
        tok_start = 1'b0; tok_kind = 2'd0;
        m_flags[2] = 1'b1;
        read_chk({tag, " R7 flag"}, 8);
        tok_done = 1'b1;
        #1;
        check({tag, " R7/R8 code"}, int'(hs_code), int'(exp_in_code()));
        tick();
        tok_done = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h1D2C3B4A));
        for (int i = 0; i < 8; i++) m_bank[i] = 8'd0;
        #(CLK_PERIOD * 3);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        read_chk("R1 flags", 8);
        read_chk("R1 enables", 9);
        read_chk("R1 control", 10);
        check("R1 irq_n", int'(irq_n), 1);
        check("R1 hs_code", int'(hs_code), 0);

        // R2, R3: setup with extra bytes beyond eight
        do_setup(10, 8'h11, "R3 setup ack");
        for (int a = 0; a < 8; a++) read_chk("R2 setup byte", a);
        read_chk("R3 flag set", 8);
        read_chk("R3 hold set", 10);

        // R10: irq follows enable
        check_irq("R10 no enable");
        cpu_write(9, 3'b001);
        check_irq("R10 setup enabled");

        // R4: refused setup keeps bytes
        do_setup(8, 8'hA0, "R4 refused setup");
        for (int a = 0; a < 8; a++) read_chk("R4 bytes kept", a);

        // R7: status held with NAK
        do_status_in("held");
        // R8: release with ZLP, then with stall
        cpu_write(10, 3'b000);
        do_status_in("released");
        cpu_write(10, 3'b010);
        do_status_in("stalled");
        // R6: OUT with stall and without
        do_data_out("stalled out");
        cpu_write(10, 3'b000);
        do_data_out("plain out");

        // R9: clear all, then clear racing a set
        cpu_write(8, 3'b111);
        read_chk("R9 w1c", 8);
        cpu_we = 1'b1; cpu_addr = 4'd8; cpu_wdata = 3'b100;
        tok_start = 1'b1; tok_kind = 2'd3;
        tick();
        cpu_we = 1'b0; tok_start = 1'b0; tok_kind = 2'd0;
        m_flags[2] = 1'b1;
        read_chk("R9 set wins", 8);
        tok_done = 1'b1;
        #1;
        check("R8 raced IN", int'(hs_code), int'(exp_in_code()));
        tick();
        tok_done = 1'b0;
        cpu_write(8, 3'b111);

        // R5: short setup
        do_setup(5, 8'h5C, "R5 short setup");
        read_chk("R5 no flag", 8);
        read_chk("R5 no hold", 10);
        for (int a = 0; a < 8; a++) read_chk("R5 partial bytes", a);

        // R11: code idle between transactions
        check("R11 idle code", int'(hs_code), 0);

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom % 7);
            case (op)
                0: do_setup(8 + int'($urandom % 3), 8'($urandom), "R3 rand setup");
                1: do_setup(int'($urandom % 8), 8'($urandom), "R5 rand short");
                2: do_data_out("rand out");
                3: do_status_in("rand in");
                4: cpu_write(8, 3'($urandom));
                5: cpu_write(9, 3'($urandom));
                default: cpu_write(10, 3'($urandom));
            endcase
            check_irq("R10 rand irq");
            read_chk("R2 rand read", int'($urandom % 11));
            cpu_addr = 4'd15;
            #1;
            check("R11 rand idle", int'(hs_code), 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule